// File: doc/BRIEF.md
# Machine-Mode Interrupt Arbiter

This block keeps the machine-mode interrupt state of a small in-order pipelined core and decides, every cycle, whether an interrupt is taken. It gathers sixteen level-sensitive platform request lines, a timer request and a software request into a pending vector. It holds the per-source enable mask and the global enable with its saved copy. When the global enable is on and at least one pending source is also enabled, it raises a take strobe with a cause code and the program counter to save.

Acceptance depends on the memory stage. A memory-stage instruction that reports an exception takes precedence, so no interrupt is taken in that cycle. No interrupt is taken while a memory or multicycle instruction in that stage is still waiting for its response. The take strobe, cause and saved PC are combinational in the current inputs and state. The status update caused by a take is applied at the next rising clock edge.

Software reaches the status word, the enable mask and the pending vector through a one-cycle CSR port: a 2-bit select, a write strobe, write data and combinational read data. A return strobe restores the global enable after a handler finishes.

Top module: `irq_arb_top`

## Requirements
- R1: Platform request line k (0..15) appears live in pending bit 16+k, read with csr_sel=2'b10. It is read-only.
- R2: Timer request appears in pending bit 7 and software request in pending bit 3. All other pending bits read 0, and csr_sel=2'b11 reads 0.
- R3: take is 1 only when status bit 3 (global enable) is 1, some pending bit is set together with its enable bit, mem_exc is 0 and mem_wait is 0. Otherwise take is 0.
- R4: While mem_exc is 1, take is 0 even if an interrupt is ready.
- R5: While mem_wait is 1, take is 0. An interrupt that is still ready is taken in the first cycle mem_wait is 0.
- R6: When take is 1, epc equals attach_pc. Otherwise epc is 0.
- R7: Among enabled pending sources the highest-numbered platform line wins, then software (bit 3), then timer (bit 7).
- R8: When take is 1, cause has bit 31 set and bits 4:0 hold the winning pending index (3, 7 or 16..31), with all other bits 0. Otherwise cause is 0.
- R9: After a take, status bit 7 (saved enable) holds the previous bit 3, and bit 3 is 0. A take overrides a simultaneous return or status write.
- R10: A return strobe without a take sets bit 3 from bit 7 and sets bit 7 to 1. It overrides a simultaneous status write.
- R11: A status write (csr_sel=2'b00) loads bits 3 and 7 only. An enable write (csr_sel=2'b01) keeps only bits 31:16, 7 and 3. Both registers reset to 0 and read back on their select.
- R12: Writes with csr_sel=2'b10 or 2'b11 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| plat_irq | input | 16 | Level-sensitive platform requests |
| timer_irq | input | 1 | Timer request level |
| soft_irq | input | 1 | Software request level |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | 00 status, 01 enable, 10 pending, 11 none |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_sel |
| mem_exc | input | 1 | Memory-stage instruction raises an exception |
| mem_wait | input | 1 | Memory-stage instruction awaits a response |
| attach_pc | input | 32 | PC of the instruction the interrupt attaches to |
| trap_ret | input | 1 | Return-from-trap strobe |
| take | output | 1 | Interrupt taken this cycle |
| cause | output | 32 | Interrupt cause code |
| epc | output | 32 | PC value to save |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 32-bit PC. At these values every pending index from 3 to 31 and the full cause encoding can be observed. A reference model runs alongside the design for long randomized stretches. These stretches cover requests appearing alone and together, with either memory-stage condition held or released. They also cover returns and status writes that land in the same cycle as a take, which exercise the update ordering.

// File: rtl/irq_arb_pkg.sv
// Package: shared widths, bit positions and CSR select codes for the
// interrupt arbiter. Assumes a 32-bit machine word.
package irq_arb_pkg;
    localparam int XLEN    = 32;
    localparam int N_PLAT  = 16;
    localparam int PLAT_LO = XLEN - N_PLAT;
    localparam int TIM_BIT = 7;
    localparam int SW_BIT  = 3;
    localparam int GE_BIT  = 3;
    localparam int SV_BIT  = 7;
    localparam int IDX_W   = $clog2(XLEN);

    typedef enum logic [1:0] {
        SEL_STATUS = 2'b00,
        SEL_ENABLE = 2'b01,
        SEL_PEND   = 2'b10,
        SEL_NONE   = 2'b11
    } csr_sel_e;

    // Enable bits that software may write.
    function automatic logic [XLEN-1:0] enable_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[XLEN-1:PLAT_LO] = '1;
        m[TIM_BIT] = 1'b1;
        m[SW_BIT]  = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/irq_arb_regs.sv
// Status and enable registers with the CSR read mux.
// Assumes that take, return and write strobes are single-cycle pulses
// from the pipeline. Update priority on the status word: take, then return,
// then software write.
module irq_arb_regs
    import irq_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [XLEN-1:0] pend,
    input  logic            take,
    input  logic            trap_ret,
    output logic            glob_en,
    output logic            prev_en,
    output logic [XLEN-1:0] en_mask,
    output logic [XLEN-1:0] csr_rdata
);
    logic wr_status, wr_enable;

    assign wr_status = csr_we && (csr_sel == SEL_STATUS);
    assign wr_enable = csr_we && (csr_sel == SEL_ENABLE);

    // Purpose: update the global enable and its saved copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            prev_en <= 1'b0;
        end else if (take) begin
            prev_en <= glob_en;
            glob_en <= 1'b0;
        end else if (trap_ret) begin
            glob_en <= prev_en;
            prev_en <= 1'b1;
        end else if (wr_status) begin
            glob_en <= csr_wdata[GE_BIT];
            prev_en <= csr_wdata[SV_BIT];
        end
    end

    // Purpose: hold the per-source enable bits, masked to the implemented set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_mask <= '0;
        else if (wr_enable)
            en_mask <= csr_wdata & enable_mask();
    end

    // Purpose: select the register returned on the read port.
    always_comb begin
        csr_rdata = '0;
        case (csr_sel)
            SEL_STATUS: begin
                csr_rdata[GE_BIT] = glob_en;
                csr_rdata[SV_BIT] = prev_en;
            end
            SEL_ENABLE: csr_rdata = en_mask;
            SEL_PEND:   csr_rdata = pend;
            default:    csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_arb_pick.sv
// Fixed-priority picker over the enabled pending vector.
// Order: highest platform line, then software, then timer.
// Assumes the bits outside the platform, timer and software positions are 0.
module irq_arb_pick
    import irq_arb_pkg::*;
(
    input  logic [XLEN-1:0]  hit,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Purpose: later assignments override earlier ones, so the lowest
    // priority source is visited first.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        if (hit[TIM_BIT]) begin
            found = 1'b1;
            idx   = IDX_W'(TIM_BIT);
        end
        if (hit[SW_BIT]) begin
            found = 1'b1;
            idx   = IDX_W'(SW_BIT);
        end
        for (int i = PLAT_LO; i < XLEN; i++) begin
            if (hit[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_arb_top.sv
// Machine-mode interrupt arbiter top. It builds the pending vector from
// the request levels, picks the winning enabled source and gates the take
// strobe with the memory-stage state.
// Assumes the request inputs are already synchronous to clk.
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PLAT-1:0]   plat_irq,
    input  logic                timer_irq,
    input  logic                soft_irq,
    input  logic                csr_we,
    input  logic [1:0]          csr_sel,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     csr_rdata,
    input  logic                mem_exc,
    input  logic                mem_wait,
    input  logic [PC_W-1:0]     attach_pc,
    input  logic                trap_ret,
    output logic                take,
    output logic [XLEN-1:0]     cause,
    output logic [PC_W-1:0]     epc
);
    logic [XLEN-1:0]  pend;
    logic [XLEN-1:0]  en_mask;
    logic             glob_en, prev_en;
    logic             found;
    logic [IDX_W-1:0] win_idx;
    logic             ready;

    // Purpose: assemble the live pending vector from the request levels.
    always_comb begin
        pend = '0;
        pend[PLAT_LO +: N_PLAT] = plat_irq;
        pend[TIM_BIT] = timer_irq;
        pend[SW_BIT]  = soft_irq;
    end

    irq_arb_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .pend      (pend),
        .take      (take),
        .trap_ret  (trap_ret),
        .glob_en   (glob_en),
        .prev_en   (prev_en),
        .en_mask   (en_mask),
        .csr_rdata (csr_rdata)
    );

    irq_arb_pick u_pick (
        .hit   (pend & en_mask),
        .found (found),
        .idx   (win_idx)
    );

    // Purpose: gate acceptance by global enable and memory-stage state.
    always_comb begin
        ready = glob_en && found;
        take  = ready && !mem_exc && !mem_wait;
        cause = '0;
        epc   = '0;
        if (take) begin
            cause = {1'b1, {(XLEN-1-IDX_W){1'b0}}, win_idx};
            epc   = attach_pc;
        end
    end
endmodule

// File: rtl/irq_arb_chk.sv
// Checker for the interrupt arbiter, bound to every instance of the top.
module irq_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            mem_exc,
    input logic            mem_wait,
    input logic            trap_ret,
    input logic            glob_en,
    input logic            prev_en,
    input logic [XLEN-1:0] cause,
    input logic [PC_W-1:0] epc,
    input logic [PC_W-1:0] attach_pc
);
    // R4
    exc_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exc |-> !take);
    // R5
    wait_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wait |-> !take);
    // R3
    take_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> glob_en);
    // R9
    take_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!glob_en && prev_en == $past(glob_en)));
    // R10
    ret_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret && !take) |=> (glob_en == $past(prev_en) && prev_en));
    // R8
    cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cause[XLEN-1]);
    // R6
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (epc == attach_pc));
endmodule

bind irq_arb_top irq_arb_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .mem_exc   (mem_exc),
    .mem_wait  (mem_wait),
    .trap_ret  (trap_ret),
    .glob_en   (glob_en),
    .prev_en   (prev_en),
    .cause     (cause),
    .epc       (epc),
    .attach_pc (attach_pc)
);

// File: tb/sim_irq_arb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the arbiter every cycle.
module sim_irq_arb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] plat_irq;
    logic        timer_irq, soft_irq, csr_we, mem_exc, mem_wait, trap_ret;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata, csr_rdata, attach_pc, cause, epc;
    logic        take;

    int total = 0;
    int bad = 0;

    // Reference model state
    bit m_ge, m_sv;
    bit [31:0] m_en;

    always #2.5 clk = ~clk;

    irq_arb_top u0 (
        .clk(clk), .rst_n(rst_n), .plat_irq(plat_irq), .timer_irq(timer_irq),
        .soft_irq(soft_irq), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_exc(mem_exc),
        .mem_wait(mem_wait), .attach_pc(attach_pc), .trap_ret(trap_ret),
        .take(take), .cause(cause), .epc(epc)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the outputs with the model, then advance the model past the edge.
    task automatic cyc();
        bit [31:0] pend, hit, exp_rd;
        int win;
        bit exp_take;
        #1;
        pend = 32'h0;
        for (int k = 0; k < 16; k++) if (plat_irq[k]) pend[16+k] = 1'b1;
        if (timer_irq) pend[7] = 1'b1;
        if (soft_irq)  pend[3] = 1'b1;
        hit = pend & m_en;
        win = -1;
        for (int k = 31; k >= 16; k--) if (win < 0 && hit[k]) win = k;
        if (win < 0 && hit[3]) win = 3;
        if (win < 0 && hit[7]) win = 7;
        exp_take = m_ge && (win >= 0) && !mem_exc && !mem_wait;
        check("R3/R4/R5 take", {31'b0, take}, {31'b0, exp_take});
        check("R7/R8 cause", cause, exp_take ? (32'h8000_0000 | win) : 32'h0);
        check("R6 epc", epc, exp_take ? attach_pc : 32'h0);
        case (csr_sel)
            2'b00: exp_rd = (m_sv ? 32'h80 : 32'h0) | (m_ge ? 32'h8 : 32'h0);
            2'b01: exp_rd = m_en;
            2'b10: exp_rd = pend;
            default: exp_rd = 32'h0;
        endcase
        check(csr_sel == 2'b00 ? "R9/R10/R11 status" :
              csr_sel == 2'b01 ? "R11 enable" : "R1/R2/R12 pending",
              csr_rdata, exp_rd);
        if (rst_n) begin
            if (exp_take) begin
                m_sv = m_ge; m_ge = 1'b0;
            end else if (trap_ret) begin
                m_ge = m_sv; m_sv = 1'b1;
            end else if (csr_we && csr_sel == 2'b00) begin
                m_ge = csr_wdata[3]; m_sv = csr_wdata[7];
            end
            if (csr_we && csr_sel == 2'b01) m_en = csr_wdata & 32'hFFFF_0088;
        end else begin
            m_ge = 0; m_sv = 0; m_en = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        plat_irq = 0; timer_irq = 0; soft_irq = 0; csr_we = 0; csr_sel = 0;
        csr_wdata = 0; mem_exc = 0; mem_wait = 0; trap_ret = 0;
        attach_pc = 32'h0000_1000;
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        idle(); csr_we = 1; csr_sel = s; csr_wdata = d; cyc();
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        cyc(); cyc();
        // R11: reset values of status and enable
        csr_sel = 2'b01; #1; check("R11 enable reset", csr_rdata, 32'h0);
        csr_sel = 2'b00; #1; check("R11 status reset", csr_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: enable mask, R12: pending and none writes ignored
        wr(2'b01, 32'hFFFF_FFFF);
        idle(); csr_sel = 2'b01; cyc();
        wr(2'b10, 32'hFFFF_FFFF);
        wr(2'b11, 32'hFFFF_FFFF);
        idle(); csr_sel = 2'b10; cyc();
        idle(); csr_sel = 2'b01; cyc();
        idle(); csr_sel = 2'b00; cyc();
        wr(2'b00, 32'h0000_0088);
        // R5: wait holds, then all sources released at once, platform 0 wins (R7)
        idle(); plat_irq = 16'h0001; timer_irq = 1; soft_irq = 1; mem_wait = 1;
        attach_pc = 32'h0000_2468; cyc(); cyc();
        mem_wait = 0; cyc();
        // R9 then R10
        idle(); csr_sel = 2'b00; cyc();
        idle(); trap_ret = 1; cyc();
        // R4: exception blocks; software beats timer
        idle(); timer_irq = 1; soft_irq = 1; mem_exc = 1; cyc();
        mem_exc = 0; cyc();
        // R1/R2: live pending read
        idle(); plat_irq = 16'hA5C3; timer_irq = 1; csr_sel = 2'b10; cyc();
        // Randomized stretch
        for (int n = 0; n < 6000; n++) begin
            plat_irq  = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            timer_irq = $urandom_range(0, 3) == 0;
            soft_irq  = $urandom_range(0, 3) == 0;
            mem_exc   = $urandom_range(0, 5) == 0;
            mem_wait  = $urandom_range(0, 4) == 0;
            trap_ret  = $urandom_range(0, 6) == 0;
            csr_we    = $urandom_range(0, 3) == 0;
            csr_sel   = 2'($urandom);
            csr_wdata = ($urandom_range(0, 1) == 0) ? 32'h88 : $urandom;
            attach_pc = $urandom;
            cyc();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule